// File: doc/BRIEF.md
# Power domain switch request sequencer

This block carries out a single power-down or power-up request for one power domain channel of a system power controller. The controller is reached through a plain 32-bit register read/write port with a valid/ready handshake. A requester gives a direction, the base offset of the channel's register group, the channel's bit index and the index of its completion interrupt bit. The block then runs the whole exchange without software. It clears the interrupt status, waits for the controller to accept commands, and writes the command. It re-issues the command while the channel's error flag stays set, waits a bounded time for completion, and clears the status again. At the end it pulses `done` with a 2-bit result.

Each of the three waits has its own bound. Polls are spaced by a programmable number of clock cycles that stands for one microsecond. The block also answers an off-state query for a channel by reading that channel's power status register. Only one operation runs at a time, and `busy` covers it.

Top module: `pwr_switch_seq`

## Requirements
- R1: After reset `busy`, `done`, `qry_done` and `bus_valid` are low.
- R2: A request (`req_valid`) is accepted only while `busy` is low. `busy` rises the cycle after acceptance and stays high until the cycle in which `done` pulses for exactly one cycle with `busy` low. Requests and queries presented while busy are ignored.
- R3: The first bus access of a request writes the one-hot mask `1 << req_isr_bit` to the interrupt clear register at address 0x08.
- R4: Before every command the block reads the global status at 0x00 and needs bit 0 set for power-off (`req_dir`=0) or bit 1 set for power-on (`req_dir`=1). Consecutive status polls are at least `CYC_PER_US` cycles apart. After `READY_POLLS` failed reads the request ends with result 2'b01, with no command and no second clear write.
- R5: A command is a write of `1 << req_chan_bit` to group+0x04 for power-off or to group+0x0C for power-on.
- R6: After every command the block reads the error register at group+0x14. While the channel's bit is set it repeats a fresh ready wait and the command. A ready wait that fails during a repeat ends the request with 2'b01.
- R7: The completion wait reads the interrupt status at 0x04 until bit `req_isr_bit` is set. Polls are spaced as in R4. After `DONE_POLLS` failed reads the result is 2'b10.
- R8: After the completion wait, whether it succeeded or timed out, the mask is written to 0x08 a second time, so a completed request makes exactly two clear writes.
- R9: A request that completes returns result 2'b00. The result is never 2'b11.
- R10: A query (`qry_valid` while idle, with `req_valid` low) reads group+0x00 and pulses `qry_done` with `qry_off` equal to bit `qry_chan_bit` of that word. If `req_valid` is high in the same cycle, the request wins and the query is dropped.
- R11: `bus_valid` stays high with stable `bus_addr`, `bus_write` and `bus_wdata` until `bus_ready`. Every write carries a one-hot data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Switch request strobe |
| req_dir | input | 1 | 0 = power off, 1 = power on |
| req_grp | input | ADDR_W | Base offset of the channel register group |
| req_chan_bit | input | IDX_W | Channel bit index |
| req_isr_bit | input | IDX_W | Completion interrupt bit index |
| qry_valid | input | 1 | Off-state query strobe |
| qry_grp | input | ADDR_W | Register group of the queried channel |
| qry_chan_bit | input | IDX_W | Bit index of the queried channel |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle request completion pulse |
| result | output | 2 | 00 ok, 01 ready timeout, 10 completion timeout |
| qry_done | output | 1 | One-cycle query completion pulse |
| qry_off | output | 1 | Queried channel is off |
| bus_valid | output | 1 | Register access request |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | DATA_W | Write data |
| bus_ready | input | 1 | Access accepted; read data valid this cycle |
| bus_rdata | input | DATA_W | Read data |

## Verification
The bench drives the block against a behavioural controller model. In that model the error flag can stay set for a chosen number of reads, readiness can vanish after the first command, completion can be withheld, and the bus can stall. A design that picked the wrong status bit for the direction would time out on a ready controller or issue the command when it should not. A retry path that skipped the fresh ready wait would miss the mid-retry abort. A final clear that depended on success would leave one clear write after a completion timeout, and one that ran after an abort would add an extra one. The exact counts of status and interrupt polls, together with the minimum spacing between back-to-back polls, expose poll bounds that are off by one and any missing spacing.

// File: rtl/pws_pkg.sv
package pws_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLR_PRE,
        ST_RDY_RD,
        ST_RDY_GAP,
        ST_CMD_WR,
        ST_ERR_RD,
        ST_CMP_RD,
        ST_CMP_GAP,
        ST_CLR_POST,
        ST_QRY_RD
    } pws_state_e;

    typedef enum logic [1:0] {
        RES_OK    = 2'b00,
        RES_AGAIN = 2'b01,
        RES_IOERR = 2'b10
    } pws_result_e;

    // global controller registers
    localparam int unsigned OFS_GSTAT = 'h00;
    localparam int unsigned OFS_ISTAT = 'h04;
    localparam int unsigned OFS_ICLR  = 'h08;
    // per-channel group registers
    localparam int unsigned OFS_PSTAT = 'h00;
    localparam int unsigned OFS_OFFC  = 'h04;
    localparam int unsigned OFS_ONC   = 'h0C;
    localparam int unsigned OFS_ERR   = 'h14;

    // status bit that must be set before a command in each direction
    localparam int unsigned RDY_BIT_OFF = 0;
    localparam int unsigned RDY_BIT_ON  = 1;

endpackage

// File: rtl/pws_gap_timer.sv
module pws_gap_timer #(
    parameter int unsigned CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CW'(CYCLES - 1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/pws_poll_budget.sv
module pws_poll_budget #(
    parameter int unsigned LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic last
);
    localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

    logic [CW-1:0] n_d, n_q;

    always_comb begin
        n_d = n_q;
        if (clear)     n_d = '0;
        else if (bump) n_d = n_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) n_q <= '0;
        else        n_q <= n_d;
    end

    // the read being made now is the final one allowed
    assign last = (n_q == CW'(LIMIT - 1));
endmodule

// File: rtl/pwr_switch_seq.sv
module pwr_switch_seq
    import pws_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned IDX_W       = $clog2(DATA_W),
    parameter int unsigned CYC_PER_US  = 250,
    parameter int unsigned READY_POLLS = 100,
    parameter int unsigned DONE_POLLS  = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_dir,
    input  logic [ADDR_W-1:0] req_grp,
    input  logic [IDX_W-1:0]  req_chan_bit,
    input  logic [IDX_W-1:0]  req_isr_bit,
    input  logic              qry_valid,
    input  logic [ADDR_W-1:0] qry_grp,
    input  logic [IDX_W-1:0]  qry_chan_bit,
    output logic              busy,
    output logic              done,
    output logic [1:0]        result,
    output logic              qry_done,
    output logic              qry_off,
    output logic              bus_valid,
    output logic              bus_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam logic [ADDR_W-1:0] A_GSTAT = ADDR_W'(OFS_GSTAT);
    localparam logic [ADDR_W-1:0] A_ISTAT = ADDR_W'(OFS_ISTAT);
    localparam logic [ADDR_W-1:0] A_ICLR  = ADDR_W'(OFS_ICLR);

    typedef struct packed {
        pws_state_e        state;
        logic              dir;
        logic [ADDR_W-1:0] grp;
        logic [IDX_W-1:0]  chan;
        logic [IDX_W-1:0]  isr;
        logic [1:0]        res;
        logic              done;
        logic              qdone;
        logic              qoff;
    } seq_t;

    seq_t s_d, s_q;

    logic tmr_start, tmr_expired;
    logic rdy_clr, rdy_bump, rdy_last;
    logic cmp_clr, cmp_bump, cmp_last;

    logic [DATA_W-1:0] isr_mask, chan_mask;
    logic              rdy_ok;

    assign isr_mask  = DATA_W'(1) << s_q.isr;
    assign chan_mask = DATA_W'(1) << s_q.chan;
    assign rdy_ok    = s_q.dir ? bus_rdata[RDY_BIT_ON] : bus_rdata[RDY_BIT_OFF];

    pws_gap_timer #(.CYCLES(CYC_PER_US)) gap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .expired (tmr_expired)
    );

    pws_poll_budget #(.LIMIT(READY_POLLS)) rdy_budget_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (rdy_clr),
        .bump  (rdy_bump),
        .last  (rdy_last)
    );

    pws_poll_budget #(.LIMIT(DONE_POLLS)) cmp_budget_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cmp_clr),
        .bump  (cmp_bump),
        .last  (cmp_last)
    );

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        s_d.qdone = 1'b0;
        tmr_start = 1'b0;
        rdy_clr   = 1'b0;
        rdy_bump  = 1'b0;
        cmp_clr   = 1'b0;
        cmp_bump  = 1'b0;
        bus_valid = 1'b0;
        bus_write = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;

        unique case (s_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.state = ST_CLR_PRE;
                    s_d.dir   = req_dir;
                    s_d.grp   = req_grp;
                    s_d.chan  = req_chan_bit;
                    s_d.isr   = req_isr_bit;
                end else if (qry_valid) begin
                    s_d.state = ST_QRY_RD;
                    s_d.grp   = qry_grp;
                    s_d.chan  = qry_chan_bit;
                end
            end

            ST_CLR_PRE: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_addr  = A_ICLR;
                bus_wdata = isr_mask;
                if (bus_ready) begin
                    s_d.state = ST_RDY_RD;
                    rdy_clr   = 1'b1;
                end
            end

            ST_RDY_RD: begin
                bus_valid = 1'b1;
                bus_addr  = A_GSTAT;
                if (bus_ready) begin
                    if (rdy_ok) begin
                        s_d.state = ST_CMD_WR;
                    end else if (rdy_last) begin
                        s_d.state = ST_IDLE;
                        s_d.res   = RES_AGAIN;
                        s_d.done  = 1'b1;
                    end else begin
                        s_d.state = ST_RDY_GAP;
                        rdy_bump  = 1'b1;
                        tmr_start = 1'b1;
                    end
                end
            end

            ST_RDY_GAP: begin
                if (tmr_expired) s_d.state = ST_RDY_RD;
            end

            ST_CMD_WR: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_addr  = s_q.grp + ADDR_W'(s_q.dir ? OFS_ONC : OFS_OFFC);
                bus_wdata = chan_mask;
                if (bus_ready) s_d.state = ST_ERR_RD;
            end

            ST_ERR_RD: begin
                bus_valid = 1'b1;
                bus_addr  = s_q.grp + ADDR_W'(OFS_ERR);
                if (bus_ready) begin
                    if (bus_rdata[s_q.chan]) begin
                        s_d.state = ST_RDY_RD;
                        rdy_clr   = 1'b1;
                    end else begin
                        s_d.state = ST_CMP_RD;
                        cmp_clr   = 1'b1;
                    end
                end
            end

            ST_CMP_RD: begin
                bus_valid = 1'b1;
                bus_addr  = A_ISTAT;
                if (bus_ready) begin
                    if (bus_rdata[s_q.isr]) begin
                        s_d.state = ST_CLR_POST;
                        s_d.res   = RES_OK;
                    end else if (cmp_last) begin
                        s_d.state = ST_CLR_POST;
                        s_d.res   = RES_IOERR;
                    end else begin
                        s_d.state = ST_CMP_GAP;
                        cmp_bump  = 1'b1;
                        tmr_start = 1'b1;
                    end
                end
            end

            ST_CMP_GAP: begin
                if (tmr_expired) s_d.state = ST_CMP_RD;
            end

            ST_CLR_POST: begin
                bus_valid = 1'b1;
                bus_write = 1'b1;
                bus_addr  = A_ICLR;
                bus_wdata = isr_mask;
                if (bus_ready) begin
                    s_d.state = ST_IDLE;
                    s_d.done  = 1'b1;
                end
            end

            ST_QRY_RD: begin
                bus_valid = 1'b1;
                bus_addr  = s_q.grp + ADDR_W'(OFS_PSTAT);
                if (bus_ready) begin
                    s_d.state = ST_IDLE;
                    s_d.qoff  = bus_rdata[s_q.chan];
                    s_d.qdone = 1'b1;
                end
            end

            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
            s_q.res   <= RES_OK;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = (s_q.state != ST_IDLE);
    assign done     = s_q.done;
    assign result   = s_q.res;
    assign qry_done = s_q.qdone;
    assign qry_off  = s_q.qoff;
endmodule

// File: rtl/pws_checker.sv
module pws_checker #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              qry_valid,
    input logic              busy,
    input logic              done,
    input logic [1:0]        result,
    input logic              qry_done,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ready
);
    a_r11_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr)
                                    && $stable(bus_write) && $stable(bus_wdata));

    a_r11_onehot_write: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_write |-> $countones(bus_wdata) == 1);

    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r2_accept_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid || qry_valid));

    a_r9_result_legal: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> result != 2'b11);

    a_r10_qry_single: assert property (@(posedge clk) disable iff (!rst_n)
        qry_done |=> !qry_done);

    a_r10_qry_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(qry_done && done));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_valid);
endmodule

bind pwr_switch_seq pws_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .qry_valid (qry_valid),
    .busy      (busy),
    .done      (done),
    .result    (result),
    .qry_done  (qry_done),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready)
);

// File: tb/pwr_switch_seq_tb_top.sv
module pwr_switch_seq_tb_top;
    localparam int AW  = 12;
    localparam int DW  = 32;
    localparam int IW  = 5;
    localparam int CPU = 4;
    localparam int RP  = 100;
    localparam int DP  = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          req_valid = 0, req_dir = 0, qry_valid = 0;
    logic [AW-1:0] req_grp = '0, qry_grp = '0;
    logic [IW-1:0] req_chan_bit = '0, req_isr_bit = '0, qry_chan_bit = '0;
    logic          busy, done, qry_done, qry_off;
    logic [1:0]    result;
    logic          bus_valid, bus_write, bus_ready;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;

    pwr_switch_seq #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW), .CYC_PER_US(CPU),
                     .READY_POLLS(RP), .DONE_POLLS(DP)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_dir(req_dir), .req_grp(req_grp),
        .req_chan_bit(req_chan_bit), .req_isr_bit(req_isr_bit),
        .qry_valid(qry_valid), .qry_grp(qry_grp), .qry_chan_bit(qry_chan_bit),
        .busy(busy), .done(done), .result(result),
        .qry_done(qry_done), .qry_off(qry_off),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata)
    );

    // ---------------- controller model ----------------
    logic [DW-1:0] gstat = '0, pstat = '0;
    logic [AW-1:0] t_grp = 12'h040;
    logic [IW-1:0] t_chan = '0, t_isr = '0;
    bit cmp_en = 1, drop_rdy = 0, stall = 0;
    int err_want = 0, base_err = 0, base_cmd = 0, mark_acc = 0;

    logic [DW-1:0] isr_reg = '0;
    logic          tog = 1'b0;
    int cyc = 0, n_acc = 0, n_clr = 0, n_off = 0, n_on = 0, n_gs = 0, n_is = 0, n_err = 0;
    int last_gs_cyc = 0, last_is_cyc = 0, min_gap = 1000000;
    bit last_was_gs = 0, last_was_is = 0;
    logic [AW-1:0] first_addr = '0;
    logic          first_wr = 0;
    logic [DW-1:0] last_cmd = '0;

    assign bus_ready = stall ? tog : 1'b1;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == 12'h000)
            bus_rdata = (drop_rdy && (n_off + n_on) > base_cmd) ? '0 : gstat;
        else if (bus_addr == 12'h004)
            bus_rdata = isr_reg;
        else if (bus_addr == t_grp + 12'h014)
            bus_rdata = ((n_err - base_err) < err_want) ? (DW'(1) << t_chan) : '0;
        else if (bus_addr == t_grp)
            bus_rdata = pstat;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        tog <= ~tog;
        if (bus_valid && bus_ready) begin
            n_acc <= n_acc + 1;
            if (n_acc == mark_acc) begin
                first_addr <= bus_addr;
                first_wr   <= bus_write;
            end
            last_was_gs <= 0;
            last_was_is <= 0;
            if (bus_write) begin
                if (bus_addr == 12'h008) begin
                    n_clr <= n_clr + 1;
                    isr_reg <= isr_reg & ~bus_wdata;
                end else if (bus_addr == t_grp + 12'h004) begin
                    n_off <= n_off + 1;
                    last_cmd <= bus_wdata;
                    if (cmp_en) isr_reg <= isr_reg | (DW'(1) << t_isr);
                end else if (bus_addr == t_grp + 12'h00C) begin
                    n_on <= n_on + 1;
                    last_cmd <= bus_wdata;
                    if (cmp_en) isr_reg <= isr_reg | (DW'(1) << t_isr);
                end
            end else begin
                if (bus_addr == 12'h000) begin
                    n_gs <= n_gs + 1;
                    if (last_was_gs && (cyc - last_gs_cyc) < min_gap) min_gap <= cyc - last_gs_cyc;
                    last_gs_cyc <= cyc;
                    last_was_gs <= 1;
                end else if (bus_addr == 12'h004) begin
                    n_is <= n_is + 1;
                    if (last_was_is && (cyc - last_is_cyc) < min_gap) min_gap <= cyc - last_is_cyc;
                    last_is_cyc <= cyc;
                    last_was_is <= 1;
                end else if (bus_addr == t_grp + 12'h014) begin
                    n_err <= n_err + 1;
                end
            end
        end
    end

    // ---------------- bookkeeping ----------------
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // snapshot of model counters at request start
    int s_clr, s_off, s_on, s_gs, s_is, s_err;
    logic [1:0] got_res;
    bit got_done, busy_at_done, saw_qry;

    task automatic snap();
        s_clr = n_clr; s_off = n_off; s_on = n_on;
        s_gs = n_gs; s_is = n_is; s_err = n_err;
        base_err = n_err; base_cmd = n_off + n_on; mark_acc = n_acc;
    endtask

    task automatic wait_done();
        got_done = 0; saw_qry = 0;
        for (int i = 0; i < 30000; i++) begin
            @(negedge clk);
            if (qry_done) saw_qry = 1;
            if (done) begin
                got_done = 1; got_res = result; busy_at_done = busy;
                break;
            end
        end
        check(got_done, "R2 done seen", got_done, 1);
    endtask

    task automatic issue(input bit dir, input logic [AW-1:0] grp,
                         input logic [IW-1:0] ch, input logic [IW-1:0] ib);
        t_grp = grp; t_chan = ch; t_isr = ib;
        snap();
        @(negedge clk);
        req_valid = 1; req_dir = dir; req_grp = grp; req_chan_bit = ch; req_isr_bit = ib;
        @(negedge clk);
        req_valid = 0;
        check(busy == 1, "R2 busy after accept", busy, 1);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check(busy == 0 && done == 0 && qry_done == 0 && bus_valid == 0,
              "R1 reset outputs", {busy, done, qry_done, bus_valid}, 0);
    endtask

    task automatic t_off_ok();
        gstat = 32'h1; cmp_en = 1; err_want = 0; drop_rdy = 0;
        issue(0, 12'h040, 5'd3, 5'd9);
        wait_done();
        check(got_res == 2'b00, "R9 off result ok", got_res, 0);
        check(busy_at_done == 0, "R2 busy low with done", busy_at_done, 0);
        check(first_wr == 1 && first_addr == 12'h008, "R3 first access is clear", first_addr, 12'h008);
        check(n_off - s_off == 1 && n_on == s_on, "R5 one off command", n_off - s_off, 1);
        check(last_cmd == 32'h8, "R5 command one-hot", last_cmd, 32'h8);
        check(n_clr - s_clr == 2, "R8 two clears on success", n_clr - s_clr, 2);
        check(isr_reg[9] == 0, "R8 status cleared after", isr_reg[9], 0);
        @(negedge clk);
        check(done == 0, "R2 done one cycle", done, 0);
    endtask

    task automatic t_on_ok_stall();
        gstat = 32'h2; cmp_en = 1; err_want = 0; stall = 1;
        issue(1, 12'h100, 5'd17, 5'd30);
        wait_done();
        stall = 0;
        check(got_res == 2'b00, "R9 on result ok", got_res, 0);
        check(n_on - s_on == 1 && n_off == s_off, "R5 on command at grp+0x0C", n_on - s_on, 1);
        check(last_cmd == 32'h0002_0000, "R5 on command data", last_cmd, 32'h0002_0000);
        check(n_clr - s_clr == 2, "R8 clears with stall", n_clr - s_clr, 2);
    endtask

    task automatic t_ready_timeout();
        gstat = 32'h1; cmp_en = 1; err_want = 0;  // bit1 clear: on must wait
        issue(1, 12'h040, 5'd2, 5'd4);
        wait_done();
        check(got_res == 2'b01, "R4 ready timeout result", got_res, 1);
        check(n_gs - s_gs == RP, "R4 status poll count", n_gs - s_gs, RP);
        check(n_on - s_on == 0 && n_off - s_off == 0, "R4 no command", n_on - s_on, 0);
        check(n_clr - s_clr == 1, "R4 no final clear", n_clr - s_clr, 1);
        check(n_is - s_is == 0, "R4 no completion wait", n_is - s_is, 0);
    endtask

    task automatic t_retry();
        gstat = 32'h3; cmp_en = 1; err_want = 2; drop_rdy = 0;
        issue(0, 12'h1C0, 5'd11, 5'd1);
        wait_done();
        check(got_res == 2'b00, "R6 retry result ok", got_res, 0);
        check(n_off - s_off == 3, "R6 command re-issued", n_off - s_off, 3);
        check(n_err - s_err == 3, "R6 error reads", n_err - s_err, 3);
        check(n_gs - s_gs == 3, "R6 fresh ready wait each try", n_gs - s_gs, 3);
        err_want = 0;
    endtask

    task automatic t_retry_abort();
        gstat = 32'h1; cmp_en = 1; err_want = 1; drop_rdy = 1;
        issue(0, 12'h040, 5'd6, 5'd6);
        wait_done();
        check(got_res == 2'b01, "R6 abort during retry", got_res, 1);
        check(n_off - s_off == 1, "R6 single command before abort", n_off - s_off, 1);
        check(n_gs - s_gs == 1 + RP, "R6 second ready wait polls", n_gs - s_gs, 1 + RP);
        check(n_clr - s_clr == 1, "R6 abort skips final clear", n_clr - s_clr, 1);
        drop_rdy = 0; err_want = 0;
    endtask

    task automatic t_cmp_timeout();
        gstat = 32'h3; cmp_en = 0; err_want = 0;
        issue(0, 12'h100, 5'd0, 5'd15);
        wait_done();
        check(got_res == 2'b10, "R7 completion timeout result", got_res, 2);
        check(n_is - s_is == DP, "R7 interrupt poll count", n_is - s_is, DP);
        check(n_clr - s_clr == 2, "R8 clear after timeout", n_clr - s_clr, 2);
        cmp_en = 1;
    endtask

    task automatic t_busy_block();
        gstat = 32'h3; cmp_en = 1; err_want = 0;
        issue(0, 12'h040, 5'd5, 5'd5);
        @(negedge clk);
        req_valid = 1; req_dir = 1; req_grp = 12'h040; qry_valid = 1;
        repeat (3) @(negedge clk);
        req_valid = 0; qry_valid = 0;
        wait_done();
        repeat (8) @(negedge clk);
        check(busy == 0, "R2 no restart after done", busy, 0);
        check(n_on - s_on == 0, "R2 request while busy ignored", n_on - s_on, 0);
        check(!saw_qry, "R2 query while busy ignored", saw_qry, 0);
    endtask

    task automatic do_query(input logic [AW-1:0] grp, input logic [IW-1:0] ch, input bit exp);
        bit seen = 0;
        bit v = 0;
        t_grp = grp;
        @(negedge clk);
        qry_valid = 1; qry_grp = grp; qry_chan_bit = ch;
        @(negedge clk);
        qry_valid = 0;
        for (int i = 0; i < 50; i++) begin
            if (qry_done) begin seen = 1; v = qry_off; break; end
            @(negedge clk);
        end
        check(seen && v == exp, "R10 query off flag", v, exp);
    endtask

    task automatic t_query();
        pstat = 32'h0000_0410;
        do_query(12'h180, 5'd4, 1);
        do_query(12'h180, 5'd5, 0);
        do_query(12'h180, 5'd10, 1);
    endtask

    task automatic t_req_wins();
        gstat = 32'h3; cmp_en = 1;
        t_grp = 12'h040; t_chan = 5'd1; t_isr = 5'd2;
        snap();
        @(negedge clk);
        req_valid = 1; req_dir = 0; req_grp = 12'h040; req_chan_bit = 5'd1; req_isr_bit = 5'd2;
        qry_valid = 1; qry_grp = 12'h040; qry_chan_bit = 5'd1;
        @(negedge clk);
        req_valid = 0; qry_valid = 0;
        wait_done();
        check(n_off - s_off == 1 && !saw_qry, "R10 request wins over query", saw_qry, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        t_reset();
        t_off_ok();
        t_on_ok_stall();
        t_ready_timeout();
        t_retry();
        t_retry_abort();
        t_cmp_timeout();
        t_busy_block();
        t_query();
        t_req_wins();
        check(min_gap >= CPU, "R4 R7 poll spacing", min_gap, CPU);
        finish_run();
    end
endmodule